// File: doc/BRIEF.md
# UART Baud Tick Generator

This block generates the sample-rate strobe for a serial port. It produces one pulse at sixteen times the bit rate. A host stores a 16-bit divisor as two bytes through a small write port. The block then counts rising edges of a slow baud reference clock and emits a single-cycle `tick` once every divisor edges. The reference clock is asynchronous to the system clock. It is brought into the system clock domain through a synchronizer, and only edges seen while `ref_en` is high are counted. The divisor is chosen as the reference frequency divided by sixteen times the wanted bit rate.

Any accepted write to either divisor byte forces the down-counter to reload on the next system clock edge. The new rate therefore takes effect at once and the old count is not finished first. `baud_out` is a registered copy of `tick`, so it changes only on system clock edges. After reset the generator stays silent until a divisor other than zero has been written. From then on, a zero divisor counts as one.

The counter sequencer is a three-state machine:

- `GEN_IDLE` is the reset state. It moves to `GEN_RUN` on a write that leaves the divisor nonzero.
- `GEN_RUN` counts qualified edges. It moves to `GEN_WRAP` when a qualified edge arrives with the count at one. It stays in `GEN_RUN` on a divisor write, on a decrement, or when there is no edge.
- `GEN_WRAP` drives `tick` for one cycle. It returns to `GEN_RUN` unless another wrap is due at once.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset (`rst` high), `tick` and `baud_out` are 0 and both divisor bytes are 0. No tick occurs, whatever edges arrive, until a write leaves the divisor nonzero.
- R2: A write happens on a `clk` rising edge where `cs_n`=0 and `wr_n`=0. `addr`=0 loads divisor bits 7:0 from `wdata`, and `addr`=1 loads bits 15:8.
- R3: While `cs_n`=1, `wr_n` pulses change neither the divisor nor the counter phase.
- R4: With divisor D (1..65535), exactly one tick occurs per D qualified reference edges. A qualified edge is a rising edge of `ref_clk` while `ref_en`=1.
- R5: An accepted write to either byte reloads the counter on the next clock edge. The next tick then comes on the D-th qualified edge after the write, whatever the count was before.
- R6: Rising edges of `ref_clk` while `ref_en`=0 are not counted.
- R7: Once running, a divisor of 0 behaves as 1, giving a tick on every qualified edge.
- R8: `tick` is high for exactly one clock cycle. It rises on the third `clk` rising edge after `ref_clk` goes high.
- R9: `baud_out` equals `tick` delayed by one clock cycle.
- R10: Both bytes form one 16-bit divisor, so a high byte of 1 and a low byte of 2 divide by 258.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | Byte select: 0 low byte, 1 high byte |
| wdata | input | 8 | Write data |
| ref_clk | input | 1 | Baud reference clock, below half the `clk` rate |
| ref_en | input | 1 | Reference clock qualifier |
| tick | output | 1 | One-cycle strobe at 16x the bit rate |
| baud_out | output | 1 | Registered copy of `tick` |

## Verification
The bench sweeps divisors 1 through 8 and checks the exact `tick` and `baud_out` cycle pattern around every reference pulse. A wrong latency or a stretched pulse shows up there, as does an off-by-one count that wraps after D-1 or D+1 edges.

It also covers the following cases:
- A zero divisor right after reset: a design that failed to gate this case would tick.
- A write while the count is partway through: a design that skipped the reload would tick early.
- A write with `cs_n` high: a design that accepted it would change the period.
- Edges arriving with the enable low: a design that counted them would shift the phase.
- A zero divisor while running: a design that stalled on zero would stop ticking.
- Divide-by-258: this exposes a high byte that is dropped or misplaced.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'b00,
        GEN_RUN  = 2'b01,
        GEN_WRAP = 2'b10
    } gen_state_e;

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [DIV_W-1:0]  div_val,
    output logic              div_wr
);
    localparam int NUM_BYTES = DIV_W / BYTE_W;

    logic              wr_hit;
    logic [BYTE_W-1:0] lane_q [NUM_BYTES];

    assign wr_hit = ~cs_n & ~wr_n;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (wr_hit && (addr == ADDR_W'(g))) begin
                lane_q[g] <= wdata;
            end
        end
        assign div_val[g*BYTE_W +: BYTE_W] = lane_q[g];
    end

    // one-cycle pulse that lines up with the updated divisor
    always_ff @(posedge clk) begin
        if (rst) begin
            div_wr <= 1'b0;
        end else begin
            div_wr <= wr_hit;
        end
    end

endmodule

// File: rtl/baud_ref_edge.sv
module baud_ref_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_clk,
    input  logic ref_en,
    output logic ref_qual
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ref_clk};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ref_qual = sync_q[SYNC_STAGES-1] & ~prev_q & ref_en;

endmodule

// File: rtl/baud_count_fsm.sv
module baud_count_fsm
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             div_wr,
    input  logic             ref_qual,
    output logic             tick,
    output logic             idle,
    output logic [DIV_W-1:0] count
);
    gen_state_e       state_q, state_d;
    logic [DIV_W-1:0] count_q, count_d;
    logic [DIV_W-1:0] eff_div;
    logic             div_nz;
    logic             last;

    assign div_nz  = |div_val;
    assign eff_div = div_nz ? div_val : DIV_W'(1);
    assign last    = (count_q <= DIV_W'(1));

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            GEN_IDLE: begin
                if (div_wr && div_nz) begin
                    state_d = GEN_RUN;
                    count_d = eff_div;
                end
            end
            GEN_RUN, GEN_WRAP: begin
                if (div_wr) begin
                    state_d = GEN_RUN;
                    count_d = eff_div;
                end else if (ref_qual) begin
                    if (last) begin
                        state_d = GEN_WRAP;
                        count_d = eff_div;
                    end else begin
                        state_d = GEN_RUN;
                        count_d = count_q - DIV_W'(1);
                    end
                end else begin
                    state_d = GEN_RUN;
                end
            end
            default: begin
                state_d = GEN_IDLE;
                count_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    always_comb begin
        tick  = (state_q == GEN_WRAP);
        idle  = (state_q == GEN_IDLE);
        count = count_q;
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter  int DIV_W       = 16,
    parameter  int BYTE_W      = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = (DIV_W / BYTE_W > 1) ? $clog2(DIV_W / BYTE_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ref_clk,
    input  logic              ref_en,
    output logic              tick,
    output logic              baud_out
);
    logic [DIV_W-1:0] div_val;
    logic             div_wr;
    logic             ref_qual;
    logic             gen_idle;
    logic [DIV_W-1:0] gen_count;

    baud_div_regs #(
        .DIV_W (DIV_W),
        .BYTE_W(BYTE_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .wdata  (wdata),
        .div_val(div_val),
        .div_wr (div_wr)
    );

    baud_ref_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .ref_clk (ref_clk),
        .ref_en  (ref_en),
        .ref_qual(ref_qual)
    );

    baud_count_fsm #(
        .DIV_W(DIV_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .div_val (div_val),
        .div_wr  (div_wr),
        .ref_qual(ref_qual),
        .tick    (tick),
        .idle    (gen_idle),
        .count   (gen_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_out <= 1'b0;
        end else begin
            baud_out <= tick;
        end
    end

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             tick,
    input logic             baud_out,
    input logic             ref_qual,
    input logic [DIV_W-1:0] div_val,
    input logic             gen_idle,
    input logic [DIV_W-1:0] gen_count
);
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst) gen_idle |=> !tick); // R1
    AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (rst) cs_n |=> $stable(div_val)); // R3
    AST_TICK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst) tick |-> $past(ref_qual)); // R4
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst) !gen_idle |-> (gen_count != '0)); // R7
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R8
    AST_BAUD_RISE: assert property (@(posedge clk) disable iff (rst) tick |=> baud_out); // R9
    AST_BAUD_LOW: assert property (@(posedge clk) disable iff (rst) !tick |=> !baud_out); // R9
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .tick     (tick),
    .baud_out (baud_out),
    .ref_qual (ref_qual),
    .div_val  (div_val),
    .gen_idle (gen_idle),
    .gen_count(gen_count)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [0:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       ref_clk = 1'b0;
    logic       ref_en = 1'b1;
    logic       tick;
    logic       baud_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    baud_tick_gen uut (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .wdata   (wdata),
        .ref_clk (ref_clk),
        .ref_en  (ref_en),
        .tick    (tick),
        .baud_out(baud_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input bit sel_n, input bit a, input logic [7:0] d);
        @(negedge clk);
        cs_n  = sel_n;
        wr_n  = 1'b0;
        addr  = a;
        wdata = d;
        @(negedge clk);
        cs_n = 1'b1;
        wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // one reference pulse; expects the tick on the 3rd sample, baud_out on the 4th
    task automatic ref_pulse(input bit exp_tick, input string req);
        logic [5:0] tp;
        logic [5:0] bp;
        logic [5:0] etp;
        logic [5:0] ebp;
        @(negedge clk);
        ref_clk = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            tp[i] = tick;
            bp[i] = baud_out;
            if (i == 2) ref_clk = 1'b0;
        end
        etp = exp_tick ? 6'b000100 : 6'b000000;
        ebp = exp_tick ? 6'b001000 : 6'b000000;
        check(tp == etp, {req, " tick"}, int'(tp), int'(etp));
        check(bp == ebp, {req, " baud_out R9"}, int'(bp), int'(ebp));
    endtask

    // n pulses, ticking when the running edge count reaches a multiple of d
    task automatic run_edges(input int d, input int start, input int n, input string req);
        for (int k = 1; k <= n; k++) begin
            ref_pulse(((start + k) % d) == 0, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state and silence with zero divisor
        check(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
        check(baud_out == 1'b0, "R1 baud_out after reset", int'(baud_out), 0);
        for (int k = 0; k < 4; k++) ref_pulse(1'b0, "R1 idle");
        reg_write(1'b0, 1'b0, 8'd0);
        reg_write(1'b0, 1'b1, 8'd0);
        for (int k = 0; k < 3; k++) ref_pulse(1'b0, "R1 zero written");

        // R2 R4 R5 R8: sweep small divisors through the low byte
        for (int d = 1; d <= 8; d++) begin
            reg_write(1'b0, 1'b0, 8'(d));
            run_edges(d, 0, 3 * d, "R4 sweep");
        end

        // R10: high byte participates, divisor 0x0102
        reg_write(1'b0, 1'b1, 8'd1);
        reg_write(1'b0, 1'b0, 8'd2);
        run_edges(258, 0, 516, "R10 div258");

        // R3: deselected write has no effect on divisor or phase
        reg_write(1'b0, 1'b1, 8'd0);
        reg_write(1'b0, 1'b0, 8'd3);
        run_edges(3, 0, 1, "R3 pre");
        reg_write(1'b1, 1'b0, 8'd5);
        reg_write(1'b1, 1'b1, 8'd7);
        run_edges(3, 1, 8, "R3 cs_n high");

        // R5: rewrite mid-count restarts the count
        reg_write(1'b0, 1'b0, 8'd5);
        run_edges(5, 0, 3, "R5 pre");
        reg_write(1'b0, 1'b0, 8'd5);
        run_edges(5, 0, 10, "R5 reload");

        // R6: edges with enable low are ignored
        reg_write(1'b0, 1'b0, 8'd2);
        run_edges(2, 0, 1, "R6 pre");
        ref_en = 1'b0;
        for (int k = 0; k < 5; k++) ref_pulse(1'b0, "R6 disabled");
        ref_en = 1'b1;
        run_edges(2, 1, 3, "R6 resumed");

        // R7: zero divisor while running acts as one
        reg_write(1'b0, 1'b0, 8'd0);
        run_edges(1, 0, 6, "R7 zero as one");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule